// File: doc/BRIEF.md
# Adder-Subtractor with Status Flags and Compare Predicates

This block is a parameterised two's complement arithmetic unit. In one combinational pass it either adds or subtracts two operands of the same width. When subtract is selected, every bit of the second operand is inverted and the carry-in of the chain is forced high, so the unit forms A plus the complement of B plus one. The same pass produces four status flags: carry, zero, negative and signed overflow.

It also derives a set of compare predicates from those flags, for both unsigned and signed operands, plus a borrow indication. A surrounding datapath uses them by issuing a subtract and reading the predicate it needs. A small flags register captures the four flags at a clock edge whenever a load strobe is high. Its reset is synchronous and active-low.

Top module: `arith_cmp_unit`

## Requirements
- R1: With `sub_en` = 0, `result` equals (`op_a` + `op_b`) modulo 2^W, and `flag_c` equals bit W of the full-width sum.
- R2: With `sub_en` = 1, `result` equals (`op_a` - `op_b`) modulo 2^W and `flag_c` = 1 exactly when `op_a` >= `op_b` unsigned. `borrow` is the inverse of `flag_c` while `sub_en` = 1, and `borrow` stays 0 while `sub_en` = 0.
- R3: `flag_z` is 1 exactly when every bit of `result` is 0.
- R4: `flag_n` equals the most significant bit of `result`.
- R5: `flag_v` is 1 exactly when the signed result is out of range. It equals the carry into the MSB XOR the carry out of the MSB.
- R6: For a subtract, the unsigned predicates hold as follows. `cmp_eq` = `flag_z`. `cmp_uge` = `flag_c`. `cmp_ult` = NOT `flag_c`. `cmp_ugt` = `flag_c` AND NOT `flag_z`. Each matches the true unsigned relation of `op_a` to `op_b`.
- R7: For a subtract, `cmp_slt` = `flag_n` XOR `flag_v` and `cmp_sge` is its inverse. Each matches the true signed relation of `op_a` to `op_b`.
- R8: `flags_q` packs the flags as bit 3 = C, bit 2 = Z, bit 1 = N, bit 0 = V. It is cleared at a clock edge while `rst_n` is low. It loads the current flags at an edge where `flag_load` is 1, and it keeps its value at any other edge.
- R9: At W = 8, 0xC0 + 0xBF gives 0x7F with V = 1 and C = 1. In subtract mode, 0xC0 - 0xBF gives 0x01 with V = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Synchronous active-low reset of the flags register |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_en | input | 1 | 1 selects A - B, 0 selects A + B |
| flag_load | input | 1 | Captures the flags into `flags_q` at the next edge |
| result | output | W | Sum or difference |
| flag_c | output | 1 | Carry out of the MSB |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result MSB |
| flag_v | output | 1 | Signed overflow |
| borrow | output | 1 | Borrow of a subtract |
| cmp_eq | output | 1 | A equals B |
| cmp_ult | output | 1 | A below B, unsigned |
| cmp_uge | output | 1 | A at or above B, unsigned |
| cmp_ugt | output | 1 | A above B, unsigned |
| cmp_slt | output | 1 | A below B, signed |
| cmp_sge | output | 1 | A at or above B, signed |
| flags_q | output | 4 | Registered flags {C,Z,N,V} |

## Verification
Carry and signed overflow can both be raised by one operation. This happens when two negative operands are added past the negative limit, or when 0x80 - 0x01 is subtracted. Zero and carry can also coincide, as in 0xFF + 0x01 and 0x05 - 0x05.

The vector table provokes each of these pairings. Every flag, and every predicate derived from a subtract, is compared against values the bench computes from the operands themselves. The registered copy is then loaded in the same cycle as such a combined case. It must show both bits together after the edge and hold them while the operands change.

// File: rtl/addsub_pkg.sv
// Shared types for the adder-subtractor.
// Assumes nothing beyond a packed flag order of C, Z, N, V (MSB to LSB).
package addsub_pkg;

    typedef struct packed {
        logic c;   // carry out of the MSB
        logic z;   // result all zero
        logic n;   // result MSB
        logic v;   // signed overflow
    } flags_t;

    localparam int FLAG_BITS = 4;

endpackage

// File: rtl/asu_carry_chain.sv
// Ripple carry chain of full-adder cells.
// Each cell forms generate and propagate terms. The chain exposes the carry
// into the top cell as well as the final carry out, because the overflow flag
// needs both. Assumes W >= 2.
module asu_carry_chain #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_top_in,
    output logic         c_out
);
    localparam int TOP = W - 1;

    logic [W:0]   carry;
    logic [W-1:0] gen;
    logic [W-1:0] prop;

    assign carry[0] = cin;

    // One full-adder cell per bit position.
    for (genvar i = 0; i < W; i++) begin : g_cell
        assign gen[i]       = a[i] & b[i];
        assign prop[i]      = a[i] ^ b[i];
        assign sum[i]       = prop[i] ^ carry[i];
        assign carry[i + 1] = gen[i] | (prop[i] & carry[i]);
    end

    assign c_top_in = carry[TOP];
    assign c_out    = carry[W];

endmodule

// File: rtl/asu_flag_gen.sv
// Status flag and compare predicate logic.
// Takes the result and the two top carries and produces C, Z, N and V, the
// borrow, and the unsigned and signed predicates. The predicates are only
// meaningful when the operation was a subtract.
module asu_flag_gen
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         c_top_in,
    input  logic         c_out,
    input  logic         sub,
    output flags_t       flags,
    output logic         borrow,
    output logic         eq,
    output logic         ult,
    output logic         uge,
    output logic         ugt,
    output logic         slt,
    output logic         sge
);
    localparam int MSB = W - 1;

    logic sign_mismatch;

    // Four status flags from the chain outputs.
    always_comb begin
        flags.c = c_out;
        flags.z = ~(|sum);
        flags.n = sum[MSB];
        flags.v = c_top_in ^ c_out;
    end

    // Predicates derived from the flags after a subtract.
    always_comb begin
        sign_mismatch = flags.n ^ flags.v;
        borrow        = sub & ~flags.c;
        eq            = flags.z;
        uge           = flags.c;
        ult           = ~flags.c;
        ugt           = flags.c & ~flags.z;
        slt           = sign_mismatch;
        sge           = ~sign_mismatch;
    end

endmodule

// File: rtl/asu_flag_reg.sv
// Flags holding register.
// Captures the flag word on an edge where load is high and keeps it
// otherwise. A synchronous active-low reset clears it to zero.
module asu_flag_reg
    import addsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    // Reset has priority over the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R8: no edge without load may change the register
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // R8: a load edge captures the flags present at that edge
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));

endmodule

// File: rtl/arith_cmp_unit.sv
// Top of the adder-subtractor with flags and compare outputs.
// The B operand is conditioned by sub_en and fed to the carry chain. The flag
// logic turns the chain outputs into flags and predicates, and a register
// keeps a copy of the flags. All outputs except flags_q are combinational.
module arith_cmp_unit
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    input  logic                 sub_en,
    input  logic                 flag_load,
    output logic [W-1:0]         result,
    output logic                 flag_c,
    output logic                 flag_z,
    output logic                 flag_n,
    output logic                 flag_v,
    output logic                 borrow,
    output logic                 cmp_eq,
    output logic                 cmp_ult,
    output logic                 cmp_uge,
    output logic                 cmp_ugt,
    output logic                 cmp_slt,
    output logic                 cmp_sge,
    output logic [FLAG_BITS-1:0] flags_q
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         c_top_in;
    logic         c_out;
    flags_t       flags;
    flags_t       flags_hold;

    // Invert B in subtract mode; the carry-in supplies the +1.
    always_comb begin
        b_eff = op_b ^ {W{sub_en}};
    end

    asu_carry_chain #(.W(W)) u_chain (
        .a        (op_a),
        .b        (b_eff),
        .cin      (sub_en),
        .sum      (result),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    asu_flag_gen #(.W(W)) u_flags (
        .sum      (result),
        .c_top_in (c_top_in),
        .c_out    (c_out),
        .sub      (sub_en),
        .flags    (flags),
        .borrow   (borrow),
        .eq       (cmp_eq),
        .ult      (cmp_ult),
        .uge      (cmp_uge),
        .ugt      (cmp_ugt),
        .slt      (cmp_slt),
        .sge      (cmp_sge)
    );

    asu_flag_reg u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_load),
        .d     (flags),
        .q     (flags_hold)
    );

    // Flatten the flag structs onto plain ports.
    always_comb begin
        flag_c  = flags.c;
        flag_z  = flags.z;
        flag_n  = flags.n;
        flag_v  = flags.v;
        flags_q = flags_hold;
    end

    // R1: in add mode the output pair is the arithmetic sum of the operands
    assert_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en |-> {flag_c, result} == ({1'b0, op_a} + {1'b0, op_b}));

    // R2: an unsigned shortfall in subtract mode must raise borrow
    assert_borrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && (op_a < op_b)) |-> borrow);

    // R3: the zero flag implies an all-zero result
    assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> (result == '0));

    // R5: overflow only when the effective operand signs agree and the result sign differs
    assert_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v |-> ((op_a[MSB] == b_eff[MSB]) && (result[MSB] != op_a[MSB])));

    // R7: signed less-than after a subtract matches the signed relation
    assert_slt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> (cmp_slt == ($signed(op_a) < $signed(op_b))));

endmodule

// File: tb/tb_arith_cmp_unit.sv
// Bench for arith_cmp_unit at W = 8.
// A table of vectors is walked first, then directed tests cover the flags register.
module tb_arith_cmp_unit;

    localparam int W = 8;
    // Vector layout: a[28:21] b[20:13] sub[12] res[11:4] {c,z,n,v}[3:0]
    localparam int NV = 13;
    localparam logic [28:0] VECS [NV] = '{
        {8'h00, 8'h00, 1'b0, 8'h00, 4'b0100},
        {8'h7F, 8'h01, 1'b0, 8'h80, 4'b0011},
        {8'hC8, 8'h64, 1'b0, 8'h2C, 4'b1000},
        {8'hC0, 8'hBF, 1'b0, 8'h7F, 4'b1001},
        {8'hC0, 8'hBF, 1'b1, 8'h01, 4'b1000},
        {8'h0A, 8'h06, 1'b1, 8'h04, 4'b1000},
        {8'h05, 8'h05, 1'b1, 8'h00, 4'b1100},
        {8'h03, 8'h07, 1'b1, 8'hFC, 4'b0010},
        {8'h80, 8'h01, 1'b1, 8'h7F, 4'b1001},
        {8'h7F, 8'hFF, 1'b1, 8'h80, 4'b0011},
        {8'hFF, 8'h01, 1'b0, 8'h00, 4'b1100},
        {8'h00, 8'h01, 1'b1, 8'hFF, 4'b0010},
        {8'h64, 8'h64, 1'b0, 8'hC8, 4'b0011}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_en = 1'b0;
    logic         flag_load = 1'b0;
    logic [W-1:0] result;
    logic         flag_c, flag_z, flag_n, flag_v, borrow;
    logic         cmp_eq, cmp_ult, cmp_uge, cmp_ugt, cmp_slt, cmp_sge;
    logic [3:0]   flags_q;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    arith_cmp_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
        .flag_load(flag_load), .result(result), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v), .borrow(borrow), .cmp_eq(cmp_eq),
        .cmp_ult(cmp_ult), .cmp_uge(cmp_uge), .cmp_ugt(cmp_ugt),
        .cmp_slt(cmp_slt), .cmp_sge(cmp_sge), .flags_q(flags_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        @(negedge clk);
        op_a = a; op_b = b; sub_en = s;
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state of the flags register (R8)
        repeat (2) @(posedge clk);
        #2;
        check("R8 reset", {28'b0, flags_q}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table: R1..R7, R9
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0] a, b, r;
            logic s, lt_u, lt_s;
            logic [3:0] f;
            a = VECS[i][28:21]; b = VECS[i][20:13]; s = VECS[i][12];
            r = VECS[i][11:4]; f = VECS[i][3:0];
            apply(a, b, s);
            check(s ? "R2 result" : "R1 result", {24'b0, result}, {24'b0, r});
            check(s ? "R2 carry" : "R1 carry", {31'b0, flag_c}, {31'b0, f[3]});
            check("R3 zero", {31'b0, flag_z}, {31'b0, f[2]});
            check("R4 negative", {31'b0, flag_n}, {31'b0, f[1]});
            check((i == 3 || i == 4) ? "R9 overflow" : "R5 overflow",
                  {31'b0, flag_v}, {31'b0, f[0]});
            lt_u = (a < b);
            lt_s = ($signed(a) < $signed(b));
            check("R2 borrow", {31'b0, borrow}, {31'b0, s & lt_u});
            if (s) begin
                check("R6 eq",  {31'b0, cmp_eq},  {31'b0, a == b});
                check("R6 ult", {31'b0, cmp_ult}, {31'b0, lt_u});
                check("R6 uge", {31'b0, cmp_uge}, {31'b0, !lt_u});
                check("R6 ugt", {31'b0, cmp_ugt}, {31'b0, a > b});
                check("R7 slt", {31'b0, cmp_slt}, {31'b0, lt_s});
                check("R7 sge", {31'b0, cmp_sge}, {31'b0, !lt_s});
            end
        end

        // R8: load a case with carry and overflow together (0x80 - 0x01)
        apply(8'h80, 8'h01, 1'b1);
        flag_load = 1'b1;
        @(posedge clk); #2;
        check("R8 load", {28'b0, flags_q}, 32'h9);
        // R8: hold while the operands change and load is low
        @(negedge clk); flag_load = 1'b0; op_a = 8'h05; op_b = 8'h05;
        @(posedge clk); #2;
        check("R8 hold", {28'b0, flags_q}, 32'h9);
        // R8: reload with zero and carry (5 - 5)
        @(negedge clk); flag_load = 1'b1;
        @(posedge clk); #2;
        check("R8 reload", {28'b0, flags_q}, 32'hC);
        // R8: synchronous reset overrides a pending load
        @(negedge clk); rst_n = 1'b0; op_a = 8'h7F; op_b = 8'hFF;
        @(posedge clk); #2;
        check("R8 reset over load", {28'b0, flags_q}, 32'h0);
        @(negedge clk); rst_n = 1'b1; flag_load = 1'b0;
        @(posedge clk); #2;
        check("R8 idle after reset", {28'b0, flags_q}, 32'h0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule